// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's 32-bit instruction fetch port and a word-wide memory read port. The processor hands over one fetch address at a time and gets back one 32-bit instruction word. The cache keeps 256 lines of four words. A fetch that finds its word in the line storage is answered without any memory traffic.

A fetch that misses pulls words into the line one at a time. It starts at the requested word and stops at the last word of the line, so words in front of the requested one are not reloaded. Each line remembers the word address where its last fill began. A later fetch to an earlier word of the same line counts as a miss, even when the upper address bits match. Per-word valid bits make sure that a word which was never filled is never returned.

Two further controls exist. With `cache_en` low when a fetch is accepted, that fetch is served straight from memory and the line storage is left alone. A one-cycle `inval` pulse empties every line.

The fetch request, the fetch response, the memory request and the memory response are all valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. Once valid is raised, it stays high and its payload stays unchanged until the transfer completes, and valid never waits on ready. The cache handles one fetch at a time and has at most one memory read in flight.

Top module: `icache_fetch`

## Requirements
- R1: After reset, `req_ready` is high and both `rsp_valid` and `mem_req_valid` are low. Every line is empty, so the first fetch to any address misses.
- R2: On a miss, the cache issues one memory read per word. The reads start at the requested word offset (address bits [3:2]) and rise to word 3, each at the word-aligned address of that word. The fetch is then answered with the requested word.
- R3: A fetch hits when four conditions hold together: address bits [31:4] equal the line's stored tag, the requested word is valid, the cache is enabled, and the address is not below the stored fill start. A hit is answered with the stored word and no memory read.
- R4: A miss does not refill the words of the line in front of the requested one. A later hit on a filled word returns the value read during the fill, even if memory has changed since.
- R5: A fetch whose word address is numerically below the line's stored fill start is a miss. Its refill begins at its own offset, and its address becomes the new fill start.
- R6: The line index is address bits [11:4] and the word is bits [3:2]. Two addresses that share an index but differ in bits [31:12] replace each other in that line.
- R7: A fetch accepted while `cache_en` is low makes exactly one memory read, at its own word address. It returns that memory word and leaves the tags, valid bits and data of the line storage unchanged.
- R8: An `inval` pulse while `req_ready` is high returns every line to the reset state: all tag and data bits are ones and all words are invalid. The next fetch to any address therefore misses.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` holds its value.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and `mem_req_addr` hold. No new memory request is raised while a memory response is still owed.
- R11: A fetch is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until the response has been taken. Fetch addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_en | input | 1 | Caching on when high; sampled with each accepted fetch |
| inval | input | 1 | Empty all lines; honoured while `req_ready` is high |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Cache can accept a fetch |
| req_addr | input | 32 | Word-aligned fetch byte address |
| rsp_valid | output | 1 | Instruction word valid |
| rsp_ready | input | 1 | Processor takes the instruction word |
| rsp_data | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Word-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Cache takes the memory read data |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The assertions rely on three things from the environment. Fetch addresses are word aligned. `inval` is only pulsed between fetches. Memory answers each accepted read with exactly one response and never sends one that was not asked for. The bench meets all three. Its driver only issues aligned addresses and pulses `inval` only while the cache is idle. Its memory model queues one response per accepted read. The model also throttles `mem_req_ready`, delays responses and stalls `rsp_ready`, so every hold rule is exercised under back-pressure.

// File: rtl/icache_pkg.sv
package icache_pkg;

  // Controller sequence for one fetch
  typedef enum logic [2:0] {
    ST_IDLE,      // waiting for a fetch
    ST_LOOK,      // tag/valid compare on the captured address
    ST_FILL_REQ,  // refill: present word read to memory
    ST_FILL_WAIT, // refill: wait for word data
    ST_BYP_REQ,   // uncached: present read to memory
    ST_BYP_WAIT,  // uncached: wait for word data
    ST_RESP       // hold the instruction word for the processor
  } fetch_state_e;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int WADDR_W = 30,
  parameter int IDX_W   = 8,
  parameter int OFF_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [WADDR_W-1:0] lk_waddr,
  output logic               lk_hit,
  input  logic               tag_we,
  input  logic [WADDR_W-1:0] tag_waddr,
  input  logic               fill_we,
  input  logic [WADDR_W-1:0] fill_waddr
);

  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  // Each entry stores the word address where the last fill started
  logic [WADDR_W-1:0] start_q [LINES];
  logic [WORDS-1:0]   vbits_q [LINES];

  logic [IDX_W-1:0]   lk_idx;
  logic [OFF_W-1:0]   lk_off;
  logic [WADDR_W-1:0] lk_start;
  logic               lk_tag_eq;
  logic               lk_below;

  assign lk_idx    = lk_waddr[OFF_W +: IDX_W];
  assign lk_off    = lk_waddr[OFF_W-1:0];
  assign lk_start  = start_q[lk_idx];
  assign lk_tag_eq = (lk_start[WADDR_W-1:OFF_W] == lk_waddr[WADDR_W-1:OFF_W]);
  assign lk_below  = (lk_waddr < lk_start);
  assign lk_hit    = lk_tag_eq && !lk_below && vbits_q[lk_idx][lk_off];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        start_q[i] <= '1;
        vbits_q[i] <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < LINES; i++) begin
        start_q[i] <= '1;
        vbits_q[i] <= '0;
      end
    end else begin
      if (tag_we) begin
        start_q[tag_waddr[OFF_W +: IDX_W]] <= tag_waddr;
        vbits_q[tag_waddr[OFF_W +: IDX_W]] <= '0;
      end
      if (fill_we) begin
        vbits_q[fill_waddr[OFF_W +: IDX_W]][fill_waddr[OFF_W-1:0]] <= 1'b1;
      end
    end
  end

  // R2: a line is retagged only at the start of a refill, never while words are arriving
  tag_fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_we && fill_we));

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int SLOTS = 1 << SLOT_W;

  // One entry per word, addressed by {line index, word offset}
  logic [DATA_W-1:0] words_q [SLOTS];

  assign rd_data = words_q[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) words_q[i] <= '1;
    end else if (clr) begin
      for (int i = 0; i < SLOTS; i++) words_q[i] <= '1;
    end else if (wr_en) begin
      words_q[wr_slot] <= wr_data;
    end
  end

endmodule

// File: rtl/icache_fetch_ctrl.sv
module icache_fetch_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cache_en,
  input  logic                     inval,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  output logic                     mem_rsp_ready,
  input  logic [DATA_W-1:0]        mem_rsp_data,
  output logic                     clr,
  output logic [ADDR_W-BYTE_W-1:0] lk_waddr,
  input  logic                     lk_hit,
  input  logic [DATA_W-1:0]        lk_data,
  output logic                     tag_we,
  output logic                     fill_we,
  output logic [ADDR_W-BYTE_W-1:0] fill_waddr,
  output logic [DATA_W-1:0]        fill_data
);

  localparam int WADDR_W = ADDR_W - BYTE_W;

  fetch_state_e        st_q;
  logic [WADDR_W-1:0]  waddr_q;
  logic                byp_q;
  logic [OFF_W-1:0]    ptr_q;
  logic [DATA_W-1:0]   word_q;
  logic [OFF_W-1:0]    req_off;
  logic                last_word;

  assign req_off   = waddr_q[OFF_W-1:0];
  assign last_word = (ptr_q == {OFF_W{1'b1}});

  // Stream outputs follow the state alone, never the partner's ready
  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_data      = word_q;
  assign mem_req_valid = (st_q == ST_FILL_REQ) || (st_q == ST_BYP_REQ);
  assign mem_rsp_ready = (st_q == ST_FILL_WAIT) || (st_q == ST_BYP_WAIT);
  assign mem_req_addr  = (st_q == ST_BYP_REQ) ? {waddr_q, {BYTE_W{1'b0}}}
                                              : {fill_waddr, {BYTE_W{1'b0}}};

  // Array side
  assign clr        = inval && (st_q == ST_IDLE);
  assign lk_waddr   = waddr_q;
  assign tag_we     = (st_q == ST_LOOK) && !byp_q && !lk_hit;
  assign fill_we    = (st_q == ST_FILL_WAIT) && mem_rsp_valid;
  assign fill_waddr = {waddr_q[WADDR_W-1:OFF_W], ptr_q};
  assign fill_data  = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      waddr_q <= '0;
      byp_q   <= 1'b0;
      ptr_q   <= '0;
      word_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            waddr_q <= req_addr[ADDR_W-1:BYTE_W];
            byp_q   <= !cache_en;
            st_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (byp_q) begin
            st_q <= ST_BYP_REQ;
          end else if (lk_hit) begin
            word_q <= lk_data;
            st_q   <= ST_RESP;
          end else begin
            ptr_q <= req_off;
            st_q  <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) st_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            if (ptr_q == req_off) word_q <= mem_rsp_data;
            if (last_word) begin
              st_q <= ST_RESP;
            end else begin
              ptr_q <= ptr_q + 1'b1;
              st_q  <= ST_FILL_REQ;
            end
          end
        end
        ST_BYP_REQ: begin
          if (mem_req_ready) st_q <= ST_BYP_WAIT;
        end
        ST_BYP_WAIT: begin
          if (mem_rsp_valid) begin
            word_q <= mem_rsp_data;
            st_q   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  fill_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (fill_waddr[OFF_W-1:0] >= req_off));

  // R2
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && last_word) |=> rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, mem_rsp_ready}));

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[BYTE_W-1:0] == '0));

  // R7
  byp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q && !req_ready |-> !(tag_we || fill_we));

endmodule

// File: rtl/icache_fetch.sv
module icache_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              inval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int IDX_W   = $clog2(LINES);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int SLOT_W  = IDX_W + OFF_W;

  logic               clr;
  logic [WADDR_W-1:0] lk_waddr;
  logic               lk_hit;
  logic [DATA_W-1:0]  lk_data;
  logic               tag_we;
  logic               fill_we;
  logic [WADDR_W-1:0] fill_waddr;
  logic [DATA_W-1:0]  fill_data;

  icache_fetch_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cache_en      (cache_en),
    .inval         (inval),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .clr           (clr),
    .lk_waddr      (lk_waddr),
    .lk_hit        (lk_hit),
    .lk_data       (lk_data),
    .tag_we        (tag_we),
    .fill_we       (fill_we),
    .fill_waddr    (fill_waddr),
    .fill_data     (fill_data)
  );

  icache_tag_store #(
    .WADDR_W (WADDR_W),
    .IDX_W   (IDX_W),
    .OFF_W   (OFF_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .lk_waddr   (lk_waddr),
    .lk_hit     (lk_hit),
    .tag_we     (tag_we),
    .tag_waddr  (lk_waddr),
    .fill_we    (fill_we),
    .fill_waddr (fill_waddr)
  );

  icache_data_store #(
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .rd_slot (lk_waddr[SLOT_W-1:0]),
    .rd_data (lk_data),
    .wr_en   (fill_we),
    .wr_slot (fill_waddr[SLOT_W-1:0]),
    .wr_data (fill_data)
  );

endmodule

// File: tb/test_icache_fetch.sv
`timescale 1ns/1ps
module test_icache_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        inval = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  icache_fetch i_icache_fetch (.*);

  int errors = 0;
  int checks = 0;
  logic [7:0]  gen = 8'd0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] rd_log [$];
  int          pending = 0;

  function automatic logic [31:0] model(input logic [31:0] a, input logic [7:0] g);
    return {a[31:2], 2'b00} ^ {g, 24'h3C5A96};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: throttled request acceptance, delayed single responses
  initial begin : mem_model
    int cyc = 0;
    int wcnt = 0;
    bit pend = 0, fire_req = 0, fire_rsp = 0, stalled = 0;
    logic [31:0] paddr = '0, saddr = '0;
    forever begin
      @(negedge clk);
      if (stalled && mem_req_valid) check("R10 request address held", mem_req_addr, saddr);
      if (mem_req_valid && (pend || (mem_rsp_valid && !fire_rsp)))
        check("R10 request while response owed", 32'd1, 32'd0);
      if (fire_rsp) mem_rsp_valid = 1'b0;
      if (fire_req) begin
        rd_log.push_back(paddr);
        pend = 1;
        wcnt = paddr[2] ? 2 : 0;
      end else if (pend && wcnt > 0) begin
        wcnt--;
      end
      if (pend && wcnt == 0 && !mem_rsp_valid) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = model(paddr, gen);
        pend = 0;
      end
      mem_req_ready = (cyc % 3) != 2;
      cyc++;
      fire_req = mem_req_valid && mem_req_ready;
      if (fire_req) paddr = mem_req_addr;
      fire_rsp = mem_rsp_valid && mem_rsp_ready;
      stalled  = mem_req_valid && !mem_req_ready;
      saddr    = mem_req_addr;
    end
  end

  // Scoreboard monitor with response back-pressure
  initial begin : monitor
    int cyc = 0;
    bit held = 0;
    logic [31:0] hdata = '0;
    forever begin
      @(negedge clk);
      if (held && rsp_valid) check("R9 response data held", rsp_data, hdata);
      if (held && !rsp_valid) check("R9 response valid held", 32'd0, 32'd1);
      rsp_ready = (cyc % 4) != 1;
      cyc++;
      held  = rsp_valid && !rsp_ready;
      hdata = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R11 unexpected response", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
          pending--;
        end
      end
    end
  end

  task automatic fetch(input string tag, input logic [31:0] a, input logic en,
                       input logic [31:0] exp, input int nrd, input logic [31:0] first);
    rd_log.delete();
    req_valid = 1'b1;
    req_addr  = a;
    cache_en  = en;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back({tag, " data"});
    pending++;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 busy after accept", {31'd0, req_ready}, 32'd0);
    wait (pending == 0);
    @(negedge clk);
    check({tag, " read count"}, rd_log.size(), nrd);
    for (int k = 0; k < nrd && k < rd_log.size(); k++)
      check({tag, " read order"}, rd_log[k], first + 32'(4 * k));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    gen = 8'd1;
    fetch("R1 R2 cold miss", 32'h100, 1'b1, model(32'h100, 1), 4, 32'h100);
    fetch("R3 hit", 32'h10C, 1'b1, model(32'h10C, 1), 0, 0);
    fetch("R4 partial fill", 32'h208, 1'b1, model(32'h208, 1), 2, 32'h208);
    gen = 8'd2;
    fetch("R4 stale word kept", 32'h20C, 1'b1, model(32'h20C, 1), 0, 0);
    fetch("R5 below fill start", 32'h204, 1'b1, model(32'h204, 2), 3, 32'h204);
    fetch("R5 refilled word", 32'h20C, 1'b1, model(32'h20C, 2), 0, 0);
    fetch("R5 below again", 32'h200, 1'b1, model(32'h200, 2), 4, 32'h200);
    fetch("R6 conflict evicts", 32'h1104, 1'b1, model(32'h1104, 2), 3, 32'h1104);
    fetch("R6 evicted line", 32'h104, 1'b1, model(32'h104, 2), 3, 32'h104);
    fetch("R6 hit after return", 32'h108, 1'b1, model(32'h108, 2), 0, 0);
    gen = 8'd3;
    fetch("R7 bypass reads memory", 32'h108, 1'b0, model(32'h108, 3), 1, 32'h108);
    fetch("R7 cached word untouched", 32'h108, 1'b1, model(32'h108, 2), 0, 0);
    fetch("R7 bypass no fill", 32'h400, 1'b0, model(32'h400, 3), 1, 32'h400);
    fetch("R7 line still empty", 32'h400, 1'b1, model(32'h400, 3), 4, 32'h400);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    fetch("R8 miss after invalidate", 32'h108, 1'b1, model(32'h108, 3), 2, 32'h108);
    fetch("R8 second line emptied", 32'h400, 1'b1, model(32'h400, 3), 4, 32'h400);
    fetch("R6 top index last word", 32'hFFC, 1'b1, model(32'hFFC, 3), 1, 32'hFFC);
    fetch("R6 top index conflict", 32'h1FF0, 1'b1, model(32'h1FF0, 3), 4, 32'h1FF0);
    fetch("R6 top index refetch", 32'hFFC, 1'b1, model(32'hFFC, 3), 1, 32'hFFC);
    fetch("R2 high address line", 32'hFFFF_FFF4, 1'b1, model(32'hFFFF_FFF4, 3), 3, 32'hFFFF_FFF4);
    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule